// File: doc/BRIEF.md
# Optical Drive Packet Command Interface Controller

This block is the device end of an ATA-style packet link for an optical drive. A host talks to it through a small register window: a 16-bit data port, a status register with a side-effect-free alias, an interrupt-reason register and a byte-count register. The host writes the packet opcode to the command register. It then pushes a 12-byte command through the data port and follows the phase that the interrupt-reason bits announce. Completion is signalled through the status phase and the interrupt line.

The only command acted on is a sector read. The start address may be given as a linear frame number or as minutes/seconds/frames. Each sector's user area is taken from a raw sector store, which is a synchronous word memory outside the block. In PIO mode the payload is served in chunks of whole sectors, sized to fit a fixed transfer buffer. Each chunk is announced with a byte count and an interrupt, and the next chunk is refilled automatically until the requested count runs out. In DMA mode an external engine pulls words one per request, and the drive stays busy until that engine reports the end of the transfer.

Top module: `pkt_drive_ctrl`

## Requirements
- R1: After reset the status register reads 0, the interrupt-reason register reads 0, the byte count reads 0 and the interrupt output is low.
- R2: Writing 0xA0 to the command register (address 1) while idle enters the packet phase. The interrupt-reason register (bit 0 = CoD, bit 1 = IO) then reads 1 and status (bit 7 = BSY, bit 3 = DRQ) reads 0x08. Any other command value is ignored.
- R3: A packet is six writes to the data port (address 0), low byte first within each word. After the sixth write, status shows BSY=1 and DRQ=0.
- R4: A read command has opcode 0x30 in byte 0, with byte 1 holding MSF select in bit 0, format in bits 3:1 (must be 2) and mask in bits 7:4 (must be 2). Each PIO data phase starts with the byte count (address 4) set to the chunk size, reason 2, status 0x08 and the interrupt raised.
- R5: Each data-port read returns the next word. The words of frame F are raw store words F*1176+8+i for i = 0..1023, that is 2048 bytes starting at byte 16 of each 2352-byte raw sector.
- R6: Without MSF, bytes 2, 3 and 4 form the 24-bit start frame, most significant first. Bytes 8, 9 and 10 form the big-endian sector count.
- R7: With MSF, the start frame is minutes*4500 + seconds*75 + frames, taken from bytes 2, 3 and 4.
- R8: Each PIO chunk holds min(remaining, floor(BUF_BYTES/2352)) sectors. When a chunk is exhausted and sectors remain, the next chunk is loaded and announced.
- R9: On completion, reason reads 3, status reads 0 and the interrupt is raised.
- R10: Reading status (address 1) drops the interrupt. Reading alternate status (address 2) returns the same value and leaves the interrupt unchanged.
- R11: An unknown opcode, a wrong format or mask, or a zero sector count completes at once with no data phase and no store read.
- R12: In DMA mode the drive stays BSY=1 without an interrupt while `dma_req` pulls words in order, one valid word the cycle after each request, up to the requested total. `dma_end` completes the command, and `dma_end` while idle is ignored.
- R13: Data-port writes outside the packet phase are ignored, and data-port reads outside a data phase return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register select: 0 data, 1 status/command, 2 alt status, 3 reason, 4 byte count |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected register |
| intrq | output | 1 | Drive interrupt request |
| dma_mode | input | 1 | Serve reads to the DMA engine instead of PIO |
| mem_rd | output | 1 | Sector store read enable |
| mem_addr | output | MEM_AW | Sector store word address |
| mem_rdata | input | 16 | Sector store data, one cycle after mem_rd |
| dma_req | input | 1 | DMA engine pulls one word |
| dma_end | input | 1 | DMA engine reports end of transfer |
| dma_valid | output | 1 | dma_data holds a pulled word |
| dma_data | output | 16 | Pulled word |

## Verification
The embedded properties assume a well-behaved host. It leaves at least one idle cycle between two data-port reads, so that the word behind the next read has been prefetched. It never asserts read and write in the same cycle. It holds `dma_mode` steady for the whole of a command. The bench drives every register access as a one-cycle strobe followed by an idle cycle, and changes `dma_mode` only while the controller is idle. It keeps `dma_req` and `dma_end` low outside the windows it is testing. On purpose, it does pull more DMA words than were requested.

// File: rtl/pkt_drive_ctrl.sv
module pkt_drive_ctrl #(
  parameter int BUF_BYTES  = 65536,
  parameter int RAW_BYTES  = 2352,
  parameter int USER_BYTES = 2048,
  parameter int USER_OFS   = 16,
  parameter int MEM_AW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              intrq,
  input  logic              dma_mode,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [15:0]       mem_rdata,
  input  logic              dma_req,
  input  logic              dma_end,
  output logic              dma_valid,
  output logic [15:0]       dma_data
);
  localparam int RAW_WORDS  = RAW_BYTES / 2;
  localparam int USER_WORDS = USER_BYTES / 2;
  localparam int HDR_WORDS  = USER_OFS / 2;
  localparam int CHUNK_SECT = BUF_BYTES / RAW_BYTES;
  localparam int WIDX_W     = $clog2(USER_WORDS);
  localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_ALT = 3'd2, A_RSN = 3'd3, A_BCNT = 3'd4;
  localparam logic [7:0] OP_READ = 8'h30;

  typedef enum logic [2:0] {S_IDLE, S_PKT, S_DEC, S_LOAD, S_FETCH, S_CAP, S_PIO, S_DMA} st_t;
  st_t st;

  logic bsy, drq, cod, io;
  logic [15:0] bcount, head, pio_word;
  logic [7:0] op, b1, b2, b3, b4, b8, b9, b10;
  logic [23:0] cur_fad, sect_left;
  logic [WIDX_W-1:0] widx;
  logic [33:0] dma_left;
  logic pio_cap_q, dma_q;

  wire wr_data = host_wr && host_addr == A_DATA;
  wire rd_data = host_rd && host_addr == A_DATA;
  wire wr_cmd  = host_wr && host_addr == A_STAT;
  wire stat_rd = host_rd && host_addr == A_STAT;

  wire last_word = ({1'b0, head} + 17'd2) == {1'b0, bcount};
  wire pio_fetch = st == S_PIO && rd_data && !last_word;
  wire dma_fetch = st == S_DMA && dma_req && dma_left != 34'd0;
  assign mem_rd = st == S_FETCH || pio_fetch || dma_fetch;

  wire [39:0] lin = 40'(cur_fad) * 40'(RAW_WORDS) + 40'(HDR_WORDS) + 40'(widx);
  assign mem_addr = lin[MEM_AW-1:0];

  wire        msf   = b1[0];
  wire [2:0]  fmt   = b1[3:1];
  wire [3:0]  mask  = b1[7:4];
  wire [23:0] count = {b8, b9, b10};
  wire [23:0] start_fad = msf ? 24'(24'(b2) * 24'd4500 + 24'(b3) * 24'd75 + 24'(b4)) : {b2, b3, b4};
  wire supported = op == OP_READ && fmt == 3'd2 && mask == 4'd2 && count != 24'd0;
  wire [23:0] chunk_n = (sect_left < 24'(CHUNK_SECT)) ? sect_left : 24'(CHUNK_SECT);

  wire done_ev = (st == S_DEC && !supported) ||
                 (st == S_PIO && rd_data && last_word && sect_left == 24'd0) ||
                 (st == S_DMA && dma_end);
  wire irq_set = done_ev || st == S_CAP;

  wire [15:0] status = {bsy, 3'b0, drq, 3'b0};

  always_comb begin
    case (host_addr)
      A_DATA:        host_rdata = (st == S_PIO) ? pio_word : 16'd0;
      A_STAT, A_ALT: host_rdata = status;
      A_RSN:         host_rdata = {14'd0, io, cod};
      A_BCNT:        host_rdata = bcount;
      default:       host_rdata = 16'd0;
    endcase
  end

  assign dma_valid = dma_q;
  assign dma_data  = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {bsy, drq, cod, io, intrq} <= '0;
      bcount <= '0; head <= '0; pio_word <= '0;
      {op, b1, b2, b3, b4, b8, b9, b10} <= '0;
      cur_fad <= '0; sect_left <= '0; widx <= '0; dma_left <= '0;
      pio_cap_q <= 1'b0; dma_q <= 1'b0;
    end else begin
      pio_cap_q <= st == S_FETCH || pio_fetch;
      dma_q     <= dma_fetch;
      if (pio_cap_q) pio_word <= mem_rdata;
      if (dma_fetch) dma_left <= dma_left - 34'd1;
      if (mem_rd) begin
        if (widx == WIDX_W'(USER_WORDS - 1)) begin
          widx <= '0;
          cur_fad <= cur_fad + 24'd1;
        end else widx <= widx + 1'b1;
      end

      if (irq_set) intrq <= 1'b1;
      else if (stat_rd) intrq <= 1'b0;

      case (st)
        S_IDLE: if (wr_cmd && host_wdata[7:0] == 8'hA0) begin
          st <= S_PKT; head <= '0;
          cod <= 1'b1; io <= 1'b0; drq <= 1'b1; bsy <= 1'b0;
        end
        S_PKT: if (wr_data) begin
          head <= head + 16'd2;
          case (head)
            16'd0:  {b1, op} <= host_wdata;
            16'd2:  {b3, b2} <= host_wdata;
            16'd4:  b4 <= host_wdata[7:0];
            16'd8:  {b9, b8} <= host_wdata;
            16'd10: b10 <= host_wdata[7:0];
            default: ;
          endcase
          if (head == 16'd10) begin
            bsy <= 1'b1; drq <= 1'b0; st <= S_DEC;
          end
        end
        S_DEC: begin
          if (!supported) st <= S_IDLE;
          else begin
            cur_fad <= start_fad; widx <= '0; sect_left <= count;
            if (dma_mode) begin
              dma_left <= 34'(count) * 34'(USER_WORDS);
              st <= S_DMA;
            end else st <= S_LOAD;
          end
        end
        S_LOAD: begin
          sect_left <= sect_left - chunk_n;
          bcount <= 16'(chunk_n * USER_BYTES);
          head <= '0;
          st <= S_FETCH;
        end
        S_FETCH: st <= S_CAP;
        S_CAP: begin
          io <= 1'b1; cod <= 1'b0; drq <= 1'b1; bsy <= 1'b0;
          st <= S_PIO;
        end
        S_PIO: if (rd_data) begin
          head <= head + 16'd2;
          if (last_word) begin
            drq <= 1'b0;
            if (sect_left != 24'd0) begin
              bsy <= 1'b1; st <= S_LOAD;
            end else st <= S_IDLE;
          end
        end
        S_DMA: if (dma_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      if (done_ev) begin
        io <= 1'b1; cod <= 1'b1; drq <= 1'b0; bsy <= 1'b0;
      end
    end
  end

  // R4
  drq_bsy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(drq && bsy));
  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !irq_set) |=> !intrq);
  // R11
  no_idle_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE || st == S_PKT) |-> !mem_rd);
  // R12
  dma_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) dma_valid |-> $past(dma_req));
  // R8
  head_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == S_PIO) |-> head < bcount);
  // R9
  status_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) (io && cod) |-> (!drq && !bsy));
endmodule

// File: tb/test_pkt_drive_ctrl.sv
module test_pkt_drive_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BUFB = 2 * 2352;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic intrq, dma_mode = 1'b0, mem_rd, dma_req = 1'b0, dma_end = 1'b0, dma_valid;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata = '0, dma_data;

  int nchk = 0, nbad = 0, ndma = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pkt_drive_ctrl #(.BUF_BYTES(BUFB)) i_pkt_drive_ctrl (
    .clk, .rst_n, .host_rd, .host_wr, .host_addr, .host_wdata, .host_rdata, .intrq,
    .dma_mode, .mem_rd, .mem_addr, .mem_rdata, .dma_req, .dma_end, .dma_valid, .dma_data);

  function automatic logic [15:0] pat(input logic [31:0] a);
    return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h5a3c;
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && dma_valid) begin
    ndma++;
    if (exp_q.size() == 0) chk("R12 extra dma word", 32'(dma_data), 32'hffffffff);
    else chk("R12 dma word", 32'(dma_data), 32'(exp_q.pop_front()));
  end

  task automatic push_sectors(input int fad, input int n);
    for (int s = 0; s < n; s++)
      for (int i = 0; i < 1024; i++) exp_q.push_back(pat(32'((fad + s) * 1176 + 8 + i)));
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!intrq && n < 3000) begin @(negedge clk); n++; end
    chk({tag, " irq"}, 32'(intrq), 32'd1);
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] a2,
                          input logic [7:0] a3, input logic [7:0] a4, input logic [23:0] cnt);
    hwrite(3'd1, 16'h00A0);
    hwrite(3'd0, {b1, op});
    hwrite(3'd0, {a3, a2});
    hwrite(3'd0, {8'h00, a4});
    hwrite(3'd0, 16'h0000);
    hwrite(3'd0, {cnt[15:8], cnt[23:16]});
    hwrite(3'd0, {8'h00, cnt[7:0]});
  endtask

  task automatic expect_done(input string tag);
    logic [15:0] d;
    wait_irq({tag, " R9"});
    hread(3'd3, d); chk({tag, " R9 reason"}, 32'(d), 32'd3);
    hread(3'd1, d); chk({tag, " R9 status"}, 32'(d), 32'd0);
    chk({tag, " R10 irq dropped"}, 32'(intrq), 32'd0);
  endtask

  task automatic pio_chunk(input int bytes);
    logic [15:0] d;
    wait_irq("R4 chunk");
    hread(3'd2, d); chk("R4 alt status", 32'(d), 32'h08);
    chk("R10 alt keeps irq", 32'(intrq), 32'd1);
    hread(3'd1, d); chk("R4 status", 32'(d), 32'h08);
    chk("R10 status drops irq", 32'(intrq), 32'd0);
    hread(3'd3, d); chk("R4 reason", 32'(d), 32'd2);
    hread(3'd4, d); chk("R8 byte count", 32'(d), 32'(bytes));
    for (int i = 0; i < bytes / 2; i++) begin
      hread(3'd0, d);
      chk("R5 pio word", 32'(d), 32'(exp_q.pop_front()));
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hread(3'd1, d); chk("R1 status", 32'(d), 32'd0);
    hread(3'd3, d); chk("R1 reason", 32'(d), 32'd0);
    hread(3'd4, d); chk("R1 byte count", 32'(d), 32'd0);
    chk("R1 irq", 32'(intrq), 32'd0);

    hwrite(3'd1, 16'h0055);
    hread(3'd3, d); chk("R2 other command ignored", 32'(d), 32'd0);
    hread(3'd0, d); chk("R13 idle data read", 32'(d), 32'd0);
    hwrite(3'd0, 16'h1234);
    hwrite(3'd1, 16'h00A0);
    hread(3'd3, d); chk("R2 reason", 32'(d), 32'd1);
    hread(3'd1, d); chk("R2 status", 32'(d), 32'h08);

    // R6 linear frame 258, 3 sectors -> chunks of 2 and 1 (R8)
    hwrite(3'd0, {8'h24, 8'h30});
    hwrite(3'd0, {8'h01, 8'h00});
    hwrite(3'd0, {8'h00, 8'h02});
    hwrite(3'd0, 16'h0000);
    hwrite(3'd0, {8'h00, 8'h00});
    hwrite(3'd0, {8'h00, 8'h03});
    hread(3'd2, d); chk("R3 busy after packet", 32'(d), 32'h80);
    push_sectors(258, 3);
    pio_chunk(4096);
    pio_chunk(2048);
    expect_done("R6");

    // R7 MSF 0:03:05 -> frame 230
    send_pkt(8'h30, 8'h25, 8'd0, 8'd3, 8'd5, 24'd1);
    push_sectors(230, 1);
    pio_chunk(2048);
    expect_done("R7");

    // R11 unknown opcode, wrong format, zero count
    send_pkt(8'h12, 8'h24, 8'd0, 8'd0, 8'd9, 24'd1);
    expect_done("R11 opcode");
    send_pkt(8'h30, 8'h26, 8'd0, 8'd0, 8'd9, 24'd1);
    expect_done("R11 format");
    send_pkt(8'h30, 8'h24, 8'd0, 8'd0, 8'd9, 24'd0);
    expect_done("R11 zero count");

    // R12 DMA
    dma_mode = 1'b1;
    @(negedge clk); dma_end = 1'b1; @(negedge clk); dma_end = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 idle dma_end irq", 32'(intrq), 32'd0);
    hread(3'd3, d); chk("R12 idle dma_end reason", 32'(d), 32'd3);
    send_pkt(8'h30, 8'h24, 8'd0, 8'd0, 8'd40, 24'd2);
    repeat (10) @(negedge clk);
    hread(3'd2, d); chk("R12 busy during dma", 32'(d), 32'h80);
    chk("R12 no irq during dma", 32'(intrq), 32'd0);
    push_sectors(40, 2);
    ndma = 0;
    @(negedge clk); dma_req = 1'b1;
    repeat (2048 + 6) @(negedge clk);
    dma_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 dma word total", 32'(ndma), 32'd2048);
    @(negedge clk); dma_end = 1'b1; @(negedge clk); dma_end = 1'b0;
    expect_done("R12");
    dma_mode = 1'b0;

    // R8 five sectors at frame 1000 -> 2, 2, 1
    send_pkt(8'h30, 8'h24, 8'h00, 8'h03, 8'hE8, 24'd5);
    push_sectors(1000, 5);
    pio_chunk(4096);
    pio_chunk(4096);
    pio_chunk(2048);
    expect_done("R8");
    chk("R5 queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule